// File: doc/BRIEF.md
# Acquisition Device Serial Port

This block is the digital side of an eight-channel, 12-bit acquisition device. It provides the serial port and the small control register. A host writes a short control word through a transmit strobe. It reads results through a receive strobe. The control word sets the channel to convert, a start flag and a standby flag. Each result frame carries a zero marker bit, the channel address in use and the converted value. The conversion core delivers that value on a parallel port.

The port has two clocking modes, selected by one input. In master mode the block makes the serial clock from its own system clock. It opens one receive frame by itself for every conversion the core reports. In slave mode the host drives both the serial clock and the receive strobe. The block passes these, together with the transmit strobe and the data input, through synchronizers and detects their edges in the system clock domain. The serial data output comes with an enable. The enable stands in for a tri-state pad, which is outside this block.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, dout_en and dout are 0, rfs_out_n is 1, the control outputs chan_sel, conv_start and standby are all 0, and in slave mode sclk_out is 0.
- R2: A result frame is 16 bits, MSB first. Bit 15 is 0. Bits 14..12 are the channel address {A2,A1,A0} from the control register. Bits 11..0 are the coded result.
- R3: With the default BIPOLAR=1, the core delivers offset binary and the frame carries two's complement: the result MSB is inverted and the other bits pass unchanged. With BIPOLAR=0 the value passes unchanged.
- R4: While the transmit strobe tfs_n is low, the first five data-in bits, taken on serial clock falling edges, form the control word. The bits arrive in the order A2, A1, A0, start, standby. The register updates when the fifth bit arrives. chan_sel = {A2,A1,A0}.
- R5: Any bits after the fifth one in the same low period of tfs_n are ignored.
- R6: If tfs_n rises before the fifth bit arrives, the control register keeps its old value.
- R7: In master mode sclk_out is high for one system clock and low for the next, without a break.
- R8: In master mode each conversion report (conv_done pulse) produces exactly one frame. rfs_out_n is low for 32 system clocks, and each frame bit is valid during a high phase of sclk_out.
- R9: In slave mode a frame starts at a falling edge of rfs_in_n. The next bit is presented after each falling edge of sclk_in, and dout_en stays 1 until the frame is released.
- R10: dout_en returns to 0 at the first serial clock rising edge after the 16th falling edge, or earlier if the receive strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ext | input | 1 | 0: master (block drives serial clock and receive strobe), 1: slave |
| sclk_in | input | 1 | Serial clock from the host (slave mode) |
| rfs_in_n | input | 1 | Active-low receive strobe from the host (slave mode) |
| tfs_n | input | 1 | Active-low transmit strobe for control writes |
| din | input | 1 | Serial control data in |
| conv_done | input | 1 | One-cycle pulse: a new result is on conv_data |
| conv_data | input | 12 | Offset-binary result from the conversion core |
| sclk_out | output | 1 | Serial clock in master mode, 0 in slave mode |
| rfs_out_n | output | 1 | Active-low receive strobe in master mode, 1 in slave mode |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Drive enable for dout (pad tri-state control) |
| chan_sel | output | 3 | Channel address {A2,A1,A0} |
| conv_start | output | 1 | Conversion start flag from the control word |
| standby | output | 1 | Standby flag from the control word |

## Verification
The bench writes seven bits where the two extra bits would move every field if they were shifted in, so a capture counter that does not stop at five changes the channel. It also aborts a write after three bits; a design that commits partial words loses the old channel. The test values for the coding are all-zero, all-one and a mixed code, so a MSB inversion that is missing or misplaced shows in the frame. The receive tests check the address field at its position. They include a slave frame cut short by the strobe, which catches a design that holds the data output until 16 edges, and a long idle gap in master mode, which catches a design that sends a frame more than once per conversion.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

   typedef enum logic {
      SP_MASTER = 1'b0,
      SP_SLAVE  = 1'b1
   } sp_mode_e;

   // Edge and level events after the mode multiplexer, one set per clk cycle
   typedef struct packed {
      logic fall;   // serial clock falls at the end of this cycle
      logic rise;   // serial clock rises at the end of this cycle
      logic start;  // receive frame opens
      logic stop;   // receive strobe returns high
      logic tlvl;   // transmit strobe level (active low)
      logic dlvl;   // serial input bit
   } sp_evt_t;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= RST_VAL;
         else        stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/adc_sp_clkgen.sv
module adc_sp_clkgen (
   input  logic clk,
   input  logic rst_n,
   input  logic master,
   input  logic conv_done,
   input  logic frame_done,
   output logic sclk_q,
   output logic rfs_q,
   output logic start
);
   logic pend;

   assign start = master & rfs_q & pend & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         rfs_q  <= 1'b1;
         pend   <= 1'b0;
      end else if (!master) begin
         sclk_q <= 1'b0;
         rfs_q  <= 1'b1;
         pend   <= 1'b0;
      end else begin
         sclk_q <= ~sclk_q;
         pend   <= conv_done | (pend & ~start);
         if (start)
            rfs_q <= 1'b0;
         else if (!rfs_q && !sclk_q && frame_done)
            rfs_q <= 1'b1;
      end
   end

   AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (master ##1 master) |-> (sclk_q != $past(sclk_q)));       // R7
   AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rfs_q) |-> $past(pend));                            // R8
endmodule

// File: rtl/adc_sp_ctrl.sv
module adc_sp_ctrl #(
   parameter int CTRL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  adc_sp_pkg::sp_evt_t evt,
   output logic [CTRL_W-1:0] ctrl_q
);
   localparam int CW = $clog2(CTRL_W + 1);
   localparam logic [CW-1:0] FULL = CW'(CTRL_W);
   localparam logic [CW-1:0] LAST = CW'(CTRL_W - 1);

   logic [CW-1:0]     cnt;
   logic [CTRL_W-1:0] sh;
   logic [CTRL_W-1:0] nxt;

   assign nxt = {sh[CTRL_W-2:0], evt.dlvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sh     <= '0;
         ctrl_q <= '0;
      end else if (evt.tlvl) begin
         cnt <= '0;
      end else if (evt.fall && cnt < FULL) begin
         sh  <= nxt;
         cnt <= cnt + 1'b1;
         if (cnt == LAST) ctrl_q <= nxt;
      end
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      evt.tlvl |=> $stable(ctrl_q));                            // R6
   AST_CTRL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && !evt.tlvl) |=> (cnt == FULL || $stable(ctrl_q))); // R5
endmodule

// File: rtl/adc_sp_tx.sv
module adc_sp_tx #(
   parameter int DATA_W  = 12,
   parameter int ADDR_W  = 3,
   parameter bit BIPOLAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  adc_sp_pkg::sp_evt_t evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] result,
   output logic              dout,
   output logic              dout_en,
   output logic              frame_done
);
   localparam int FRAME_W = 1 + ADDR_W + DATA_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] ALL = CNT_W'(FRAME_W);

   logic [DATA_W-1:0]  coded;
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;
   logic               en;

   if (BIPOLAR) begin : g_twos
      assign coded = {~result[DATA_W-1], result[DATA_W-2:0]};
   end else begin : g_straight
      assign coded = result;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
         en  <= 1'b0;
      end else if (evt.start) begin
         sh  <= {1'b0, addr, coded};
         cnt <= '0;
         en  <= 1'b1;
      end else if (en && (evt.stop || (evt.rise && cnt == ALL))) begin
         en  <= 1'b0;
      end else if (en && evt.fall && cnt < ALL) begin
         sh  <= {sh[FRAME_W-2:0], 1'b0};
         cnt <= cnt + 1'b1;
      end
   end

   assign dout       = en & sh[FRAME_W-1];
   assign dout_en    = en;
   assign frame_done = en && (cnt == ALL);

   AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (dout_en && !dout));                        // R2
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && evt.stop && !evt.start) |=> !dout_en);             // R10
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
   parameter int DATA_W      = 12,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit BIPOLAR     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_ext,
   input  logic              sclk_in,
   input  logic              rfs_in_n,
   input  logic              tfs_n,
   input  logic              din,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              sclk_out,
   output logic              rfs_out_n,
   output logic              dout,
   output logic              dout_en,
   output logic [ADDR_W-1:0] chan_sel,
   output logic              conv_start,
   output logic              standby
);
   import adc_sp_pkg::*;

   localparam int CTRL_W = ADDR_W + 2;

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   sp_mode_e mode;
   assign mode = sp_mode_e'(mode_ext);

   // synchronized host signals: {sclk, rfs, tfs, din}
   logic [3:0] sy;
   logic       s_prev, r_prev;

   adc_sp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sclk_in, rfs_in_n, tfs_n, din}),
      .q(sy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_prev <= 1'b1;
         r_prev <= 1'b1;
      end else begin
         s_prev <= sy[3];
         r_prev <= sy[2];
      end
   end

   logic m_sclk, m_rfs, m_start, frame_done;
   sp_evt_t evt;

   always_comb begin
      if (mode == SP_MASTER) begin
         evt.fall  = m_sclk;
         evt.rise  = ~m_sclk;
         evt.start = m_start;
         evt.stop  = 1'b0;
         evt.tlvl  = tfs_n;
         evt.dlvl  = din;
      end else begin
         evt.fall  = s_prev & ~sy[3];
         evt.rise  = ~s_prev & sy[3];
         evt.start = r_prev & ~sy[2];
         evt.stop  = ~r_prev & sy[2];
         evt.tlvl  = sy[1];
         evt.dlvl  = sy[0];
      end
   end

   adc_sp_clkgen u_clkgen (
      .clk(clk), .rst_n(rst_n),
      .master(mode == SP_MASTER),
      .conv_done(conv_done),
      .frame_done(frame_done),
      .sclk_q(m_sclk),
      .rfs_q(m_rfs),
      .start(m_start)
   );

   logic [CTRL_W-1:0] ctrl_q;

   adc_sp_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .evt(evt), .ctrl_q(ctrl_q)
   );

   logic [DATA_W-1:0] res_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         res_q <= '0;
      else if (conv_done) res_q <= conv_data;
   end

   adc_sp_tx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BIPOLAR(BIPOLAR)) u_tx (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .addr(chan_sel), .result(res_q),
      .dout(dout), .dout_en(dout_en), .frame_done(frame_done)
   );

   assign chan_sel   = ctrl_q[CTRL_W-1 -: ADDR_W];
   assign conv_start = ctrl_q[1];
   assign standby    = ctrl_q[0];
   assign sclk_out   = m_sclk;
   assign rfs_out_n  = m_rfs;

   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SP_SLAVE) |=> rfs_out_n);                        // R1
endmodule

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_ext = 1'b1, sclk_in = 1'b1, rfs_in_n = 1'b1, tfs_n = 1'b1, din = 1'b0;
   logic conv_done = 1'b0;
   logic [11:0] conv_data = '0;
   logic sclk_out, rfs_out_n, dout, dout_en, conv_start, standby;
   logic [2:0] chan_sel;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // behavioural reference state
   logic [4:0]  m_ctrl = '0;
   logic [11:0] m_raw  = '0;
   logic [15:0] m_q[$];

   always #5 clk = ~clk;

   adc_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .sclk_in(sclk_in),
      .rfs_in_n(rfs_in_n), .tfs_n(tfs_n), .din(din), .conv_done(conv_done),
      .conv_data(conv_data), .sclk_out(sclk_out), .rfs_out_n(rfs_out_n),
      .dout(dout), .dout_en(dout_en), .chan_sel(chan_sel),
      .conv_start(conv_start), .standby(standby)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] frame_of(input logic [4:0] c, input logic [11:0] raw);
      return {1'b0, c[4:2], ~raw[11], raw[10:0]};
   endfunction

   task automatic chk_ctrl(input string req);
      chk({req, " chan"}, chan_sel, m_ctrl[4:2]);
      chk({req, " start"}, conv_start, m_ctrl[1]);
      chk({req, " stby"}, standby, m_ctrl[0]);
   endtask

   // bits taken from v[7], v[6], ...
   task automatic slave_write(input logic [7:0] v, input int n);
      tfs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         din = v[7-i];
         repeat (4) @(negedge clk);
         sclk_in = 1'b0;
         repeat (8) @(negedge clk);
         sclk_in = 1'b1;
         repeat (4) @(negedge clk);
      end
      tfs_n = 1'b1;
      repeat (8) @(negedge clk);
      if (n >= 5) m_ctrl = v[7:3];
   endtask

   task automatic master_write(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (sclk_out !== 1'b0);
         tfs_n = 1'b0;
         din   = v[7-i];
      end
      do @(negedge clk); while (sclk_out !== 1'b0);
      tfs_n = 1'b1;
      repeat (4) @(negedge clk);
      if (n >= 5) m_ctrl = v[7:3];
   endtask

   task automatic pulse_conv(input logic [11:0] raw);
      @(negedge clk);
      conv_done = 1'b1;
      conv_data = raw;
      @(negedge clk);
      conv_done = 1'b0;
      m_raw = raw;
   endtask

   task automatic slave_read(input int n);
      logic [15:0] exp = frame_of(m_ctrl, m_raw);
      rfs_in_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R9 en at start", dout_en, 1);
      for (int i = 0; i < n; i++) begin
         chk($sformatf("R2 slave bit %0d", 15 - i), dout, exp[15-i]);
         sclk_in = 1'b0;
         repeat (8) @(negedge clk);
         sclk_in = 1'b1;
         repeat (8) @(negedge clk);
      end
      if (n == 16) begin
         chk("R10 release after last rise", dout_en, 0);
         rfs_in_n = 1'b1;
      end else begin
         chk("R9 en held mid-frame", dout_en, 1);
         rfs_in_n = 1'b1;
         repeat (8) @(negedge clk);
         chk("R10 release on strobe rise", dout_en, 0);
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic master_read(input logic [11:0] raw);
      logic [15:0] got = '0;
      logic [15:0] exp;
      int lows = 0, nb = 0, w = 0;
      pulse_conv(raw);
      m_q.push_back(frame_of(m_ctrl, raw));
      while (rfs_out_n !== 1'b0 && w < 40) begin @(negedge clk); w++; end
      while (rfs_out_n === 1'b0 && lows < 100) begin
         if (sclk_out === 1'b1) begin
            got = {got[14:0], dout};
            nb++;
         end
         lows++;
         @(negedge clk);
      end
      exp = m_q.pop_front();
      chk("R8 strobe low cycles", lows, 32);
      chk("R8 bits in frame", nb, 16);
      chk("R2 R3 master frame", got, exp);
      chk("R10 release at frame end", dout_en, 0);
      w = 0;
      repeat (80) begin
         @(negedge clk);
         if (rfs_out_n !== 1'b1) w++;
      end
      chk("R8 no second frame", w, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1 reset state
      chk("R1 dout_en", dout_en, 0);
      chk("R1 dout", dout, 0);
      chk("R1 rfs_out_n", rfs_out_n, 1);
      chk("R1 sclk_out", sclk_out, 0);
      chk_ctrl("R1");

      // R4/R5: seven bits, extra two would shift everything
      slave_write(8'b1011_0110, 7);
      chk_ctrl("R4 R5 slave write");
      // R6: aborted write after three bits
      slave_write(8'b0000_0000, 3);
      chk_ctrl("R6 aborted write");

      // R9/R2/R3 slave reads
      pulse_conv(12'h123);
      slave_read(16);
      pulse_conv(12'h800);
      slave_read(16);
      pulse_conv(12'h5A5);
      slave_read(4);

      // master mode
      mode_ext = 1'b0;
      repeat (4) @(negedge clk);
      begin
         int alt = 0;
         logic last;
         last = sclk_out;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sclk_out === ~last) alt++;
            last = sclk_out;
         end
         chk("R7 sclk toggles each cycle", alt, 12);
      end
      master_write(8'b0110_1100, 6);
      chk_ctrl("R4 R5 master write");
      master_read(12'hFFF);
      master_read(12'h000);
      master_write(8'b1110_0000, 5);
      chk_ctrl("R4 master write two");
      master_read(12'h7C1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule